// File: doc/BRIEF.md
# Unsigned Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a small DSP-style core. It holds a bank of 40-bit accumulators. A strobe runs one of three unsigned operations on two 16-bit operands: **put** loads the product into an accumulator, **add** adds the product to it, and **sub** subtracts the product from it. A fourth operation code, **peek**, writes nothing and only reports the selected accumulator.

Both operands are zero-extended, and the multiply keeps the full 32-bit product. In fractional mode the product is doubled, and it is carried at 33 bits so that no bit is lost. Every update wraps modulo 2^40 and there is no saturation.

The updated value appears on a registered output. A one-cycle done pulse marks it in the cycle after the strobe.

Top module: `umac_unit`

## Requirements
- R1: Operands `inA` and `inB` are treated as unsigned 16-bit values. The product is kept at its full 32 bits, so 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R2: When `inFrac` is 1, the product is shifted left by one bit and carried at 33 bits before use. For example, 0xFFFF times 0xFFFF stored in fractional mode gives 0x1FFFC0002.
- R3: Operation code 0 (put) writes the product into the selected accumulator, zero-extended to 40 bits.
- R4: Operation code 1 (add) writes the accumulator plus the product, modulo 2^40.
- R5: Operation code 2 (sub) writes the accumulator minus the product, modulo 2^40. For example, 1 minus 2 gives 0xFFFFFFFFFF.
- R6: Operation code 3 (peek) changes no accumulator. It reports the selected accumulator's current value.
- R7: `inIdx` selects the accumulator that an operation reads and writes. The other accumulator keeps its value.
- R8: `outValid` is high in exactly the cycles that follow a cycle with `inValid` high. `outAcc` holds its value while no operation completes.
- R9: Reset (`rstN` low) clears every accumulator and `outAcc` to zero, and drops `outValid`.
- R10: Operations on consecutive cycles to the same accumulator chain. Each one uses the value that the previous one wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Starts an operation this cycle |
| inOp | input | 2 | 0 put, 1 add, 2 sub, 3 peek |
| inIdx | input | 1 | Accumulator select |
| inA | input | 16 | First unsigned operand |
| inB | input | 16 | Second unsigned operand |
| inFrac | input | 1 | Fractional mode: double the product |
| outValid | output | 1 | Done pulse, one cycle after `inValid` |
| outAcc | output | 40 | Result of the last completed operation |

## Verification
Some behaviour the checker tests on every cycle:
- the done pulse tracks the strobe one cycle later;
- `outAcc` stays stable between completions;
- a put leaves the exact zero-extended product, or the doubled product, on the output;
- reset clears the outputs.

Other behaviour depends on accumulator contents that are not visible at the ports, so only the bench's reference model and directed scenarios can show it. This covers add and sub wrapping across 2^40, peek reading back an untouched accumulator, isolation between the two accumulators, and back-to-back chaining.

// File: rtl/umac_pkg.sv
package umac_pkg;

  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_PEEK = 2'd3
  } macOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic go;    // an operation completes at this edge
    logic wr;    // the selected accumulator is written
    logic put;   // replace instead of combine
    logic sub;   // combine by subtraction
    logic frac;  // double the product
  } macCtl_t;

endpackage

// File: rtl/umac_ctrl.sv
module umac_ctrl
  import umac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inOp,
  input  logic       inFrac,
  output macCtl_t    ctl,
  output logic       doneQ
);

  macOp_e op;
  assign op = macOp_e'(inOp);

  always_comb begin
    ctl.go   = inValid;
    ctl.wr   = inValid && (op != OP_PEEK);
    ctl.put  = (op == OP_PUT);
    ctl.sub  = (op == OP_SUB);
    ctl.frac = inFrac;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= inValid;
  end

endmodule

// File: rtl/umac_prod.sv
module umac_prod #(
  parameter int OPW = 16,
  localparam int PRODW = 2 * OPW,
  localparam int SHW = PRODW + 1
) (
  input  logic [OPW-1:0] opA,
  input  logic [OPW-1:0] opB,
  input  logic           frac,
  output logic [SHW-1:0] prodSh
);

  logic [PRODW-1:0] prod;

  // zero-extend both operands, keep the full product
  assign prod = PRODW'(opA) * PRODW'(opB);

  always_comb begin
    if (frac) prodSh = {prod, 1'b0};
    else      prodSh = {1'b0, prod};
  end

endmodule

// File: rtl/umac_dp.sv
module umac_dp
  import umac_pkg::*;
#(
  parameter int OPW = 16,
  parameter int ACCW = 40,
  parameter int NACC = 2,
  localparam int IDXW = (NACC > 1) ? $clog2(NACC) : 1,
  localparam int SHW = 2 * OPW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  macCtl_t         ctl,
  input  logic [IDXW-1:0] inIdx,
  input  logic [OPW-1:0]  inA,
  input  logic [OPW-1:0]  inB,
  output logic [ACCW-1:0] resQ
);

  logic [SHW-1:0]  prodSh;
  logic [ACCW-1:0] prodExt;
  logic [ACCW-1:0] curAcc;
  logic [ACCW-1:0] nextAcc;
  logic [ACCW-1:0] accQ [NACC];

  umac_prod #(.OPW(OPW)) u_prod (
    .opA   (inA),
    .opB   (inB),
    .frac  (ctl.frac),
    .prodSh(prodSh)
  );

  assign prodExt = ACCW'(prodSh);
  assign curAcc  = accQ[inIdx];

  // wraps naturally at ACCW bits
  always_comb begin
    if (ctl.put)      nextAcc = prodExt;
    else if (ctl.sub) nextAcc = curAcc - prodExt;
    else              nextAcc = curAcc + prodExt;
  end

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        accQ[g] <= '0;
      else if (ctl.wr && (inIdx == IDXW'(g)))
        accQ[g] <= nextAcc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       resQ <= '0;
    else if (ctl.go) resQ <= ctl.wr ? nextAcc : curAcc;
  end

endmodule

// File: rtl/umac_unit.sv
module umac_unit
  import umac_pkg::*;
#(
  parameter int OPW = 16,
  parameter int ACCW = 40,
  parameter int NACC = 2,
  localparam int IDXW = (NACC > 1) ? $clog2(NACC) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [1:0]      inOp,
  input  logic [IDXW-1:0] inIdx,
  input  logic [OPW-1:0]  inA,
  input  logic [OPW-1:0]  inB,
  input  logic            inFrac,
  output logic            outValid,
  output logic [ACCW-1:0] outAcc
);

  macCtl_t ctl;

  umac_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inOp   (inOp),
    .inFrac (inFrac),
    .ctl    (ctl),
    .doneQ  (outValid)
  );

  umac_dp #(.OPW(OPW), .ACCW(ACCW), .NACC(NACC)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .inIdx(inIdx),
    .inA  (inA),
    .inB  (inB),
    .resQ (outAcc)
  );

endmodule

// File: rtl/umac_chk.sv
module umac_chk #(
  parameter int OPW = 16,
  parameter int ACCW = 40
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [1:0]      inOp,
  input logic [OPW-1:0]  inA,
  input logic [OPW-1:0]  inB,
  input logic            inFrac,
  input logic            outValid,
  input logic [ACCW-1:0] outAcc
);

  // R8
  done_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R8
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outAcc));

  // R1 R3
  put_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'd0 && !inFrac) |=>
      outAcc == ACCW'($past(inA)) * ACCW'($past(inB)));

  // R2
  put_frac_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'd0 && inFrac) |=>
      outAcc == ((ACCW'($past(inA)) * ACCW'($past(inB))) << 1));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (outAcc == '0 && !outValid));

endmodule

bind umac_unit umac_chk #(.OPW(OPW), .ACCW(ACCW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inOp    (inOp),
  .inA     (inA),
  .inB     (inB),
  .inFrac  (inFrac),
  .outValid(outValid),
  .outAcc  (outAcc)
);

// File: tb/sim_umac_unit.sv
`timescale 1ns/1ps
module sim_umac_unit;

  localparam longint MASK = (64'd1 << 40) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inOp = 2'd0;
  logic [0:0]  inIdx = 1'b0;
  logic [15:0] inA = '0;
  logic [15:0] inB = '0;
  logic        inFrac = 1'b0;
  logic        outValid;
  logic [39:0] outAcc;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  umac_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inIdx(inIdx),
    .inA(inA), .inB(inB), .inFrac(inFrac), .outValid(outValid), .outAcc(outAcc)
  );

  // behavioural reference model
  longint mAcc [2];
  longint mOut;
  bit     mValid;
  string  mTag;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAcc[0] = 0; mAcc[1] = 0; mOut = 0; mValid = 0; mTag = "R9";
    end else begin
      mValid = inValid;
      if (inValid) begin
        longint p;
        p = longint'(inA) * longint'(inB);
        if (inFrac) p = p * 2;
        case (inOp)
          2'd0: begin mAcc[inIdx] = p; mTag = inFrac ? "R2" : "R3"; end
          2'd1: begin mAcc[inIdx] = (mAcc[inIdx] + p) & MASK; mTag = "R4"; end
          2'd2: begin mAcc[inIdx] = (mAcc[inIdx] - p) & MASK; mTag = "R5"; end
          default: mTag = "R6";
        endcase
        mOut = mAcc[inIdx];
      end else begin
        mTag = "R8";
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (outValid !== mValid || outAcc !== 40'(mOut)) begin
        errors++;
        $display("FAIL %s per-cycle: valid=%0b acc=%h expected valid=%0b acc=%h",
                 mTag, outValid, outAcc, mValid, 40'(mOut));
      end
    end
  end

  task automatic expect_out(input string tag, input logic v, input longint acc);
    checks++;
    if (outValid !== v || outAcc !== 40'(acc)) begin
      errors++;
      $display("FAIL %s: valid=%0b acc=%h expected valid=%0b acc=%h",
               tag, outValid, outAcc, v, 40'(acc));
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic idx, input logic [15:0] a,
                       input logic [15:0] b, input logic fr);
    inValid = 1'b1; inOp = op; inIdx = idx; inA = a; inB = b; inFrac = fr;
  endtask

  task automatic single(input logic [1:0] op, input logic idx, input logic [15:0] a,
                        input logic [15:0] b, input logic fr, input string tag,
                        input longint acc);
    @(negedge clk); drive(op, idx, a, b, fr);
    @(negedge clk); inValid = 1'b0;
    expect_out(tag, 1'b1, acc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R9", 1'b0, 0);            // reset state
    rstN = 1'b1;

    single(2'd0, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0, "R1", 64'hFFFE0001);
    single(2'd0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, "R2", 64'h1FFFC0002);
    single(2'd3, 1'b0, 16'h0, 16'h0, 1'b0, "R7", 64'hFFFE0001);
    single(2'd0, 1'b0, 16'd1, 16'd1, 1'b0, "R3", 1);
    single(2'd2, 1'b0, 16'd2, 16'd1, 1'b0, "R5", 64'hFF_FFFF_FFFF);
    single(2'd1, 1'b0, 16'd1, 16'd1, 1'b0, "R4", 0);
    single(2'd3, 1'b1, 16'h1234, 16'h5678, 1'b1, "R6", 64'h1FFFC0002);
    @(negedge clk);
    expect_out("R8", 1'b0, 64'h1FFFC0002);

    // back-to-back chaining
    @(negedge clk); drive(2'd0, 1'b0, 16'd3, 16'd4, 1'b0);
    @(negedge clk); drive(2'd1, 1'b0, 16'd5, 16'd5, 1'b0);
    expect_out("R10", 1'b1, 12);
    @(negedge clk); inValid = 1'b0;
    expect_out("R10", 1'b1, 37);

    // reset mid-run clears accumulators
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); expect_out("R9", 1'b0, 0);
    rstN = 1'b1;
    single(2'd3, 1'b1, 16'd0, 16'd0, 1'b0, "R9", 0);

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      inValid = ($urandom % 4) != 0;
      inOp    = 2'($urandom);
      inIdx   = 1'($urandom);
      inA     = ($urandom % 3 == 0) ? 16'hFFFF : 16'($urandom);
      inB     = 16'($urandom);
      inFrac  = 1'($urandom);
    end
    @(negedge clk); inValid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule